// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block passes short messages between an application processor and an I/O co-processor over one shared register bus. It contains two independent message queues. The outbound queue carries traffic from the application side to the I/O side. The inbound queue carries traffic the other way. Each message is a 64-bit word plus a 32-bit payload.

A sender writes the first word into a staging register. It then writes the payload, and that second write places the whole message in the queue. A receiver may read the head word without removing it. Reading the payload register removes the message, and the same read returns the queue's indices and fill levels in the upper bits.

Four latched interrupt sources report the empty and not-empty state of each queue. A latched source stays set until software acknowledges it. An enable mask chooses which latched sources drive the single interrupt line.

Top module: `mbx_top`

## Requirements
- R1: After a synchronous active-high reset, both control registers read full (bit 16) = 0, empty (bit 17) = 1 and overflow (bit 18) = 0. The enable register reads 0 and `irq_o` is low.
- R2: A bus read returns its data with `bus_rvalid_o` one cycle after the request. Outbound queue offsets are: control 0x50, send first word 0x60, send payload 0x68, receive first word 0x70, receive payload 0x78. A write to the send-first-word offset only stages the word. A write to the send-payload offset appends {staged word, write data bits 31:0}. A read of the receive-first-word offset returns the head word and leaves the queue unchanged. A read of the receive-payload offset returns the head payload in bits 31:0 and removes that message. Messages leave in the order they entered.
- R3: A queue holding 16 messages reads full = 1. A payload write to a full queue is discarded and sets the sticky overflow bit 18. Writing a 1 to bit 18 of that control register clears the overflow bit.
- R4: A payload read of an empty queue returns 0 in bits 31:0 and leaves the indices and the fill level unchanged. A first-word read of an empty queue returns 0.
- R5: A payload read reports the queue state as it was before the removal. Bits 56:52 hold the number of messages held. Bits 51:48 hold the free slots, saturated at 15. Bits 47:44 hold the read index and bits 43:40 the write index. Bits 63:57 and 39:32 read 0.
- R6: The inbound queue uses control 0x80, send 0x90/0x98 and receive 0xA0/0xA8. Traffic on one queue never changes the other queue's state.
- R7: Offset 0x4C reads the latched sources: bit 0 outbound empty, bit 1 outbound not-empty, bit 2 inbound empty, bit 3 inbound not-empty. A bit sets when its condition holds and stays set after the condition goes away.
- R8: Writing a 1 to a bit at 0x4C clears that latched bit in the following cycle. If the condition still holds, the bit sets again one cycle later, so a message that arrived before the acknowledge is still signalled.
- R9: Offset 0x48 holds a 4-bit enable mask and can be read back. `irq_o` is the OR over the four sources of (latched AND enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Bus access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Level interrupt from the enabled latched sources |

## Verification
The hardest situation to reach is an acknowledge of the not-empty source while a message is still queued. There, the interrupt line must drop for exactly one cycle and then return. The stimulus fills the inbound queue, waits until the source is latched, and writes the acknowledge. It then samples `irq_o` on each of the next two cycles. A second hard case is the overflow path, which only opens after sixteen back-to-back pushes. The bench fills the queue completely, pushes once more, and then drains all sixteen entries through its scoreboard. This shows that the extra message was discarded and that nothing was overwritten.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NUM_CH    = 2;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int NUM_IRQ   = 2 * NUM_CH;
    localparam int ADDR_W    = 8;
    localparam int BUS_W     = 64;
    localparam int PAYLOAD_W = 32;

    localparam int ST_FULL_BIT  = 16;
    localparam int ST_EMPTY_BIT = 17;
    localparam int ST_OVF_BIT   = 18;

    localparam logic [ADDR_W-1:0] OFF_IRQ_EN  = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_IRQ_ACK = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_CTRL [NUM_CH] = '{8'h50, 8'h80};

    localparam logic [ADDR_W-1:0] SEND0_DELTA = 8'h10;
    localparam logic [ADDR_W-1:0] SEND1_DELTA = 8'h18;
    localparam logic [ADDR_W-1:0] RECV0_DELTA = 8'h20;
    localparam logic [ADDR_W-1:0] RECV1_DELTA = 8'h28;

    typedef struct packed {
        logic [BUS_W-1:0]     w0;
        logic [PAYLOAD_W-1:0] w1;
    } mbx_msg_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_SEND0,
        RS_SEND1,
        RS_RECV0,
        RS_RECV1,
        RS_IRQ_EN,
        RS_IRQ_ACK
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic [CH_W-1:0] ch;
    } reg_hit_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        h.sel = RS_NONE;
        h.ch  = '0;
        if (a == OFF_IRQ_EN)  h.sel = RS_IRQ_EN;
        if (a == OFF_IRQ_ACK) h.sel = RS_IRQ_ACK;
        for (int c = 0; c < NUM_CH; c++) begin
            if (a == OFF_CTRL[c]) begin
                h.sel = RS_CTRL;  h.ch = c[CH_W-1:0];
            end
            if (a == OFF_CTRL[c] + SEND0_DELTA) begin
                h.sel = RS_SEND0; h.ch = c[CH_W-1:0];
            end
            if (a == OFF_CTRL[c] + SEND1_DELTA) begin
                h.sel = RS_SEND1; h.ch = c[CH_W-1:0];
            end
            if (a == OFF_CTRL[c] + RECV0_DELTA) begin
                h.sel = RS_RECV0; h.ch = c[CH_W-1:0];
            end
            if (a == OFF_CTRL[c] + RECV1_DELTA) begin
                h.sel = RS_RECV1; h.ch = c[CH_W-1:0];
            end
        end
        return h;
    endfunction

    function automatic logic [3:0] free_field(input int unsigned used,
                                              input int unsigned depth);
        int unsigned f;
        f = depth - used;
        return (f > 15) ? 4'd15 : f[3:0];
    endfunction

    function automatic logic [BUS_W-1:0] pack_word1(
        input logic [PAYLOAD_W-1:0] pl,
        input logic [4:0]           held,
        input logic [3:0]           free,
        input logic [3:0]           rd_idx,
        input logic [3:0]           wr_idx);
        return {7'b0, held, free, rd_idx, wr_idx, 8'b0, pl};
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo import mbx_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  mbx_msg_t                     data_i,
    input  logic                         pop_i,
    input  logic                         ovf_clr_i,
    output mbx_msg_t                     head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic [$clog2(DEPTH)-1:0]     rptr_o,
    output logic [$clog2(DEPTH)-1:0]     wptr_o,
    output logic                         full_o,
    output logic                         empty_o,
    output logic                         ovf_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    mbx_msg_t        mem [DEPTH];
    logic [PW-1:0]   wptr_q, rptr_q;
    logic [CW-1:0]   cnt_q;
    logic            ovf_q;
    logic            do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) wptr_q <= bump(wptr_q);
            if (do_pop)  rptr_q <= bump(rptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push_i && full_o) ovf_q <= 1'b1;
            else if (ovf_clr_i)   ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= data_i;
    end

    assign head_o  = mem[rptr_q];
    assign count_o = cnt_q;
    assign rptr_o  = rptr_q;
    assign wptr_o  = wptr_q;
    assign ovf_o   = ovf_q;

    // R3: a push into a full queue leaves the fill level and write index alone
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i) |=> ($stable(cnt_q) && $stable(wptr_q) && ovf_q));

    // R4: a removal from an empty queue moves nothing
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o && !push_i) |=> ($stable(rptr_q) && empty_o));

    // R5: the reported fill level never exceeds the depth
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] latch_o,
    output logic         irq_o
);
    logic [N-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= (latch_q | cond_i) & ~ack_i;
    end

    assign latch_o = latch_q;
    assign irq_o   = |(latch_q & en_i);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7: a latched source holds until acknowledged
        p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (latch_q[i] && !ack_i[i]) |=> latch_q[i]);
        // R8: an acknowledge clears the source in the following cycle
        p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
            ack_i[i] |=> !latch_q[i]);
        // R8: a live condition without acknowledge always sets the latch
        p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
            (cond_i[i] && !ack_i[i]) |=> latch_q[i]);
    end

endmodule

// File: rtl/mbx_top.sv
module mbx_top import mbx_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [63:0]       bus_wdata_i,
    output logic [63:0]       bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              irq_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    reg_hit_t            hit;
    logic                wr, rd;

    mbx_msg_t            head_w   [NUM_CH];
    logic [CW-1:0]       cnt_w    [NUM_CH];
    logic [PW-1:0]       rptr_w   [NUM_CH];
    logic [PW-1:0]       wptr_w   [NUM_CH];
    logic [NUM_CH-1:0]   full_w, empty_w, ovf_w;
    logic [NUM_CH-1:0]   push_w, pop_w, ovf_clr_w;
    logic [BUS_W-1:0]    stage_q  [NUM_CH];

    logic [NUM_IRQ-1:0]  irq_en_q;
    logic [NUM_IRQ-1:0]  ack_w, cond_w, latch_w;

    logic [BUS_W-1:0]    rd_mux;
    logic [BUS_W-1:0]    rdata_q;
    logic                rvalid_q;

    assign hit = decode_addr(bus_addr_i);
    assign wr  = bus_req_i && bus_we_i;
    assign rd  = bus_req_i && !bus_we_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic mine;
        assign mine         = (hit.ch == CH_W'(g));
        assign push_w[g]    = wr && mine && (hit.sel == RS_SEND1);
        assign pop_w[g]     = rd && mine && (hit.sel == RS_RECV1);
        assign ovf_clr_w[g] = wr && mine && (hit.sel == RS_CTRL) && bus_wdata_i[ST_OVF_BIT];

        always_ff @(posedge clk) begin
            if (rst)                                     stage_q[g] <= '0;
            else if (wr && mine && hit.sel == RS_SEND0)  stage_q[g] <= bus_wdata_i;
        end

        mbx_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push_i    (push_w[g]),
            .data_i    ('{w0: stage_q[g], w1: bus_wdata_i[PAYLOAD_W-1:0]}),
            .pop_i     (pop_w[g]),
            .ovf_clr_i (ovf_clr_w[g]),
            .head_o    (head_w[g]),
            .count_o   (cnt_w[g]),
            .rptr_o    (rptr_w[g]),
            .wptr_o    (wptr_w[g]),
            .full_o    (full_w[g]),
            .empty_o   (empty_w[g]),
            .ovf_o     (ovf_w[g])
        );

        assign cond_w[2*g]     = empty_w[g];
        assign cond_w[2*g + 1] = !empty_w[g];

        // R2: an accepted push makes the queue non-empty next cycle
        p_push_fills_r2: assert property (@(posedge clk) disable iff (rst)
            (push_w[g] && !full_w[g]) |=> !empty_w[g]);
    end

    always_ff @(posedge clk) begin
        if (rst)                           irq_en_q <= '0;
        else if (wr && hit.sel == RS_IRQ_EN) irq_en_q <= bus_wdata_i[NUM_IRQ-1:0];
    end

    assign ack_w = (wr && hit.sel == RS_IRQ_ACK) ? bus_wdata_i[NUM_IRQ-1:0] : '0;

    mbx_irq #(.N(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cond_w),
        .ack_i   (ack_w),
        .en_i    (irq_en_q),
        .latch_o (latch_w),
        .irq_o   (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        case (hit.sel)
            RS_CTRL: begin
                rd_mux[ST_FULL_BIT]  = full_w[hit.ch];
                rd_mux[ST_EMPTY_BIT] = empty_w[hit.ch];
                rd_mux[ST_OVF_BIT]   = ovf_w[hit.ch];
            end
            RS_RECV0:   rd_mux = empty_w[hit.ch] ? '0 : head_w[hit.ch].w0;
            RS_RECV1:   rd_mux = pack_word1(
                            empty_w[hit.ch] ? '0 : head_w[hit.ch].w1,
                            5'(cnt_w[hit.ch]),
                            free_field(int'(cnt_w[hit.ch]), DEPTH),
                            4'(rptr_w[hit.ch]),
                            4'(wptr_w[hit.ch]));
            RS_IRQ_EN:  rd_mux[NUM_IRQ-1:0] = irq_en_q;
            RS_IRQ_ACK: rd_mux[NUM_IRQ-1:0] = latch_w;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;

    // R9: the interrupt line needs at least one enabled source
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_en_q != '0));

endmodule

// File: tb/test_mbx_top.sv
module test_mbx_top;
    localparam int DEPTH = 16;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we  = 1'b0;
    logic [7:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rvalid;
    logic        irq;

    always #5 clk = ~clk;

    mbx_top #(.DEPTH(DEPTH)) i_mbx_top (
        .clk          (clk),
        .rst          (rst),
        .bus_req_i    (req),
        .bus_we_i     (we),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_rvalid_o (rvalid),
        .irq_o        (irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic [63:0] exp;
        logic [63:0] mask;
        string       tag;
    } exp_t;

    exp_t         expq [$];
    logic [95:0]  sb0 [$];
    logic [95:0]  sb1 [$];
    int           m_cnt [2];
    int           m_rp  [2];
    int           m_wp  [2];

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each returned read against the scoreboard queue
    always @(negedge clk) begin
        exp_t e;
        if (!rst && rvalid) begin
            if (expq.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2 unexpected read actual=%h expected=none", rdata);
            end else begin
                e = expq.pop_front();
                check64(e.tag, rdata & e.mask, e.exp & e.mask);
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [63:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; wdata = '0;
        x.exp = e; x.mask = ONES; x.tag = tag;
        expq.push_back(x);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req = 1'b0; we = 1'b0;
        end
    endtask

    task automatic check_irq(input string tag, input logic exp);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        check64(tag, {63'b0, irq}, {63'b0, exp});
    endtask

    function automatic logic [63:0] ctrl_val(input bit full, input bit empty, input bit ovf);
        logic [63:0] v;
        v = '0;
        v[16] = full; v[17] = empty; v[18] = ovf;
        return v;
    endfunction

    function automatic logic [63:0] word1_val(input logic [31:0] p, input int cnt,
                                              input int rp, input int wp);
        int f;
        f = DEPTH - cnt;
        if (f > 15) f = 15;
        return {7'b0, 5'(cnt), 4'(f), 4'(rp), 4'(wp), 8'b0, p};
    endfunction

    task automatic send(input int ch, input logic [63:0] w0, input logic [31:0] w1);
        bus_wr(ch != 0 ? 8'h90 : 8'h60, w0);
        bus_wr(ch != 0 ? 8'h98 : 8'h68, {32'hDEAD_BEEF, w1});
        if (m_cnt[ch] < DEPTH) begin
            if (ch != 0) sb1.push_back({w0, w1});
            else         sb0.push_back({w0, w1});
            m_wp[ch]  = (m_wp[ch] + 1) % DEPTH;
            m_cnt[ch] = m_cnt[ch] + 1;
        end
    endtask

    task automatic recv(input int ch, input string tag);
        logic [95:0] m;
        m = '0;
        if (m_cnt[ch] > 0) m = (ch != 0) ? sb1[0] : sb0[0];
        bus_rd(ch != 0 ? 8'hA0 : 8'h70, m[95:32], tag);
        bus_rd(ch != 0 ? 8'hA8 : 8'h78, word1_val(m[31:0], m_cnt[ch], m_rp[ch], m_wp[ch]), tag);
        if (m_cnt[ch] > 0) begin
            if (ch != 0) void'(sb1.pop_front());
            else         void'(sb0.pop_front());
            m_rp[ch]  = (m_rp[ch] + 1) % DEPTH;
            m_cnt[ch] = m_cnt[ch] - 1;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 0; m_rp[c] = 0; m_wp[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_irq("R1 irq low after reset", 1'b0);
        bus_rd(8'h50, ctrl_val(0, 1, 0), "R1 outbound control after reset");
        bus_rd(8'h80, ctrl_val(0, 1, 0), "R1 inbound control after reset");
        bus_rd(8'h48, 64'h0, "R1 enable mask after reset");
        bus_rd(8'h4C, 64'h5, "R7 empty sources latched");

        // R2, R5: ordered transfer with bookkeeping fields
        for (int i = 0; i < 3; i++)
            send(0, {32'hA0A0_0000 + 32'(i), 32'h1234_0000 + 32'(i)}, 32'hC000_0000 + 32'(i));
        for (int i = 0; i < 3; i++) recv(0, "R2 R5 outbound order and fields");

        // R7: not-empty stays latched after the queue drains
        bus_rd(8'h4C, 64'h7, "R7 not-empty held after drain");

        // R8: acknowledge with condition gone, then with condition live
        bus_wr(8'h4C, 64'h2);
        idle(2);
        bus_rd(8'h4C, 64'h5, "R8 acked source stays clear");
        bus_wr(8'h4C, 64'h1);
        bus_rd(8'h4C, 64'h4, "R8 source clear right after ack");
        bus_rd(8'h4C, 64'h5, "R8 source rearmed while empty");

        // R4: reads of an empty queue
        recv(0, "R4 empty read first");
        recv(0, "R4 empty read second");

        // R3: fill, overflow, clear, drain
        for (int i = 0; i < DEPTH; i++)
            send(0, {32'hB0B0_0000 + 32'(i), 32'h5555_0000 + 32'(i)}, 32'hF000_0000 + 32'(i));
        bus_rd(8'h50, ctrl_val(1, 0, 0), "R3 full flag");
        send(0, 64'hBAD0_BAD0_BAD0_BAD0, 32'hBAD0_0001);
        bus_rd(8'h50, ctrl_val(1, 0, 1), "R3 overflow sticky");
        bus_wr(8'h50, 64'h4_0000);
        bus_rd(8'h50, ctrl_val(1, 0, 0), "R3 overflow cleared");
        for (int i = 0; i < DEPTH; i++) recv(0, "R3 R5 drain after overflow");
        bus_rd(8'h50, ctrl_val(0, 1, 0), "R3 empty after drain");

        // R6: inbound queue independent of outbound queue
        send(1, 64'h1111_2222_3333_4444, 32'h5555_6666);
        send(1, 64'h7777_8888_9999_AAAA, 32'hBBBB_CCCC);
        bus_rd(8'h80, ctrl_val(0, 0, 0), "R6 inbound holds messages");
        bus_rd(8'h50, ctrl_val(0, 1, 0), "R6 outbound untouched");
        recv(1, "R6 inbound order");
        recv(1, "R6 inbound order");

        // R9: mask and interrupt line
        bus_wr(8'h4C, 64'hF);
        bus_wr(8'h48, 64'h8);
        bus_rd(8'h48, 64'h8, "R9 enable readback");
        check_irq("R9 disabled sources masked", 1'b0);
        send(1, 64'hCAFE_0000_0000_0001, 32'h0000_0001);
        idle(1);
        check_irq("R9 irq on inbound not-empty", 1'b1);
        recv(1, "R6 inbound single");
        check_irq("R7 irq held after drain", 1'b1);
        bus_wr(8'h4C, 64'h8);
        check_irq("R8 irq clear after ack", 1'b0);
        check_irq("R8 irq stays clear when empty", 1'b0);

        // R8: acknowledge while a message waits
        send(1, 64'hCAFE_0000_0000_0002, 32'h0000_0002);
        idle(2);
        bus_wr(8'h4C, 64'h8);
        check_irq("R8 one-cycle drop on live ack", 1'b0);
        check_irq("R8 live message re-raises irq", 1'b1);
        recv(1, "R6 inbound after live ack");
        idle(3);

        n_checks++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending reads actual=%0d expected=0", expq.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule